// File: doc/BRIEF.md
# Code-Breaking Game Controller

This block runs a single-player code-breaking game. While idle in its start state it keeps sampling a free-running pseudo-random word and stores it as a hidden code of four 3-bit colour slots. The code freezes once play begins. The player sets a 12-bit guess on switches and raises, then lowers, a submit switch. The controller then scores the guess slot by slot and uses up one of nine turns.

For a seven-segment driver, the block exposes three 4-bit values: turns remaining, slots that hold the right colour in the right place, and slots whose colour appears elsewhere in the code. When the game ends it raises either a win flag or a lose flag. It also presents a two-digit end pattern: 6,6 for a win and 6,0 for a loss. A new-game switch restarts play from any state and captures a fresh code. The submit and new-game switches are asynchronous to the clock and are resynchronized inside the block.

Top module: `codebreak_ctrl`

## Requirements
- R1: While rst_ni is low, the outputs are: turns_o = 9, spot_o = 0, color_o = 0, win_o = 0, lose_o = 0, end_digits_o = 8'h00. These values appear without waiting for a clock edge.
- R2: A synchronized high on new_game_i returns the controller to its start state from any state. That start state shows turns_o = 9, zero counts and no end flags.
- R3: While in the start state, rand_i is copied into the hidden code. Slot k occupies bits [3k+2:3k]. After the first submit the code no longer follows rand_i.
- R4: Each guess needs submit_i to go high and then low. A guess consumes exactly one turn, so turns_o falls by one per guess.
- R5: spot_o equals the number of slots k in which the guess slot equals code slot k.
- R6: A guess slot that misses its own code slot but equals any of the other three code slots adds one to color_o. Repeats are not deduplicated.
- R7: When spot_o reaches 4, win_o goes high and end_digits_o = 8'h66. Later submits change no output until the next new game.
- R8: When turns_o reaches 0 without a full match, lose_o goes high and end_digits_o = 8'h60. Later submits change no output.
- R9: If the ninth guess is a full match, the game is a win and not a loss. win_o and lose_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| new_game_i | input | 1 | Restart switch, asynchronous level |
| submit_i | input | 1 | Submit switch, asynchronous level |
| rand_i | input | 12 | Free-running pseudo-random word |
| guess_i | input | 12 | Guess switches, slot k at bits [3k+2:3k] |
| turns_o | output | 4 | Turns remaining |
| spot_o | output | 4 | Right colour, right slot count |
| color_o | output | 4 | Right colour, wrong slot count |
| win_o | output | 1 | Game won |
| lose_o | output | 1 | Game lost |
| end_digits_o | output | 8 | End pattern as two BCD digits (66 win, 60 loss, else 00) |

## Verification
The bench builds the block with its default parameters: four slots of three bits and nine turns. With this configuration every full game fits in a few hundred cycles. Scripted games cover the repeated-colour cases of the colour rule, a loss on the ninth turn, a win on the ninth turn, and submits made after the game has ended. A long sweep of arithmetically generated codes and guesses, with automatic restarts, drives many complete games. Each guess is compared against a scoring model written independently in the bench.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_SUBMIT = 2'd1,
    ST_SHOW   = 2'd2,
    ST_END    = 2'd3
  } cb_state_e;

  localparam logic [7:0] WIN_DIGITS  = 8'h66;
  localparam logic [7:0] LOSE_DIGITS = 8'h60;
endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cb_scorer.sv
module cb_scorer #(
  parameter int SLOTS   = 4,
  parameter int COLOR_W = 3,
  localparam int CODE_W = SLOTS * COLOR_W
) (
  input  logic [CODE_W-1:0] guess_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [SLOTS-1:0]  spot_flags_o,
  output logic [SLOTS-1:0]  color_flags_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic [COLOR_W-1:0] g;
    logic               hit;
    assign g = guess_i[i*COLOR_W +: COLOR_W];

    always_comb begin
      hit = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && g == code_i[j*COLOR_W +: COLOR_W]) hit = 1'b1;
      end
    end

    assign spot_flags_o[i]  = (g == code_i[i*COLOR_W +: COLOR_W]);
    assign color_flags_o[i] = !spot_flags_o[i] && hit;
  end
endmodule

// File: rtl/codebreak_ctrl.sv
module codebreak_ctrl #(
  parameter int SLOTS       = 4,
  parameter int COLOR_W     = 3,
  parameter int TURNS       = 9,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W     = SLOTS * COLOR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_game_i,
  input  logic              submit_i,
  input  logic [CODE_W-1:0] rand_i,
  input  logic [CODE_W-1:0] guess_i,
  output logic [CNT_W-1:0]  turns_o,
  output logic [CNT_W-1:0]  spot_o,
  output logic [CNT_W-1:0]  color_o,
  output logic              win_o,
  output logic              lose_o,
  output logic [7:0]        end_digits_o
);
  import cb_pkg::*;

  localparam logic [CNT_W-1:0] TURNS_C = CNT_W'(TURNS);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  logic              new_game_s, submit_s;
  cb_state_e         state_q;
  logic [CODE_W-1:0] code_q;
  logic [SLOTS-1:0]  spot_f_q, color_f_q, spot_f, color_f;
  logic              dec_en_q;
  logic [CNT_W-1:0]  turns_q, spot_q, color_q;
  logic [CNT_W-1:0]  turns_nxt, spot_sum, color_sum;

  cb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({new_game_i, submit_i}),
    .q_o    ({new_game_s, submit_s})
  );

  cb_scorer #(.SLOTS(SLOTS), .COLOR_W(COLOR_W)) u_scorer (
    .guess_i       (guess_i),
    .code_i        (code_q),
    .spot_flags_o  (spot_f),
    .color_flags_o (color_f)
  );

  always_comb begin
    spot_sum  = '0;
    color_sum = '0;
    for (int i = 0; i < SLOTS; i++) begin
      spot_sum  = spot_sum  + CNT_W'(spot_f_q[i]);
      color_sum = color_sum + CNT_W'(color_f_q[i]);
    end
    turns_nxt = dec_en_q ? turns_q - CNT_W'(1) : turns_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_INIT;
      code_q    <= '0;
      spot_f_q  <= '0;
      color_f_q <= '0;
      dec_en_q  <= 1'b0;
      turns_q   <= TURNS_C;
      spot_q    <= '0;
      color_q   <= '0;
    end else if (new_game_s) begin
      state_q   <= ST_INIT;
      spot_f_q  <= '0;
      color_f_q <= '0;
      dec_en_q  <= 1'b0;
      turns_q   <= TURNS_C;
      spot_q    <= '0;
      color_q   <= '0;
    end else begin
      unique case (state_q)
        ST_INIT: begin
          code_q   <= rand_i;
          turns_q  <= TURNS_C;
          spot_q   <= '0;
          color_q  <= '0;
          dec_en_q <= 1'b0;
          if (submit_s) state_q <= ST_SUBMIT;
        end
        ST_SUBMIT: begin
          dec_en_q  <= 1'b1;
          spot_f_q  <= spot_f;
          color_f_q <= color_f;
          if (!submit_s) state_q <= ST_SHOW;
        end
        ST_SHOW: begin
          turns_q  <= turns_nxt;
          dec_en_q <= 1'b0;
          spot_q   <= spot_sum;
          color_q  <= color_sum;
          if (turns_nxt == '0 || spot_sum == SLOTS_C) state_q <= ST_END;
          else if (submit_s)                          state_q <= ST_SUBMIT;
        end
        default: ;
      endcase
    end
  end

  assign turns_o      = turns_q;
  assign spot_o       = spot_q;
  assign color_o      = color_q;
  // full match outranks exhausted turns
  assign win_o        = (state_q == ST_END) && (spot_q == SLOTS_C);
  assign lose_o       = (state_q == ST_END) && !win_o;
  assign end_digits_o = win_o ? WIN_DIGITS : (lose_o ? LOSE_DIGITS : 8'h00);
endmodule

// File: rtl/cb_checker.sv
module cb_checker #(
  parameter int SLOTS   = 4,
  parameter int COLOR_W = 3,
  parameter int TURNS   = 9,
  parameter int CNT_W   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       new_game_s,
  input cb_pkg::cb_state_e          state_q,
  input logic [SLOTS*COLOR_W-1:0]   code_q,
  input logic [CNT_W-1:0]           turns_o,
  input logic [CNT_W-1:0]           spot_o,
  input logic [CNT_W-1:0]           color_o,
  input logic                       win_o,
  input logic                       lose_o
);
  import cb_pkg::*;

  p_turns_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(turns_o) <= TURNS);

  p_turns_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (turns_o != $past(turns_o)) |->
      (int'(turns_o) + 1 == int'($past(turns_o))) || (int'(turns_o) == TURNS));

  p_code_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_INIT && $past(state_q) != ST_INIT) |-> $stable(code_q));

  p_counts_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(spot_o) + int'(color_o) <= SLOTS);

  p_win_lose_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win_o && lose_o));

  p_win_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_o && !new_game_s) |=> win_o);

  p_lose_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lose_o && !new_game_s) |=> lose_o);

  p_lose_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lose_o |-> (turns_o == '0));
endmodule

bind codebreak_ctrl cb_checker #(
  .SLOTS(SLOTS), .COLOR_W(COLOR_W), .TURNS(TURNS), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .new_game_s (new_game_s),
  .state_q    (state_q),
  .code_q     (code_q),
  .turns_o    (turns_o),
  .spot_o     (spot_o),
  .color_o    (color_o),
  .win_o      (win_o),
  .lose_o     (lose_o)
);

// File: tb/codebreak_ctrl_bench.sv
module codebreak_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        new_game_i = 1'b0;
  logic        submit_i = 1'b0;
  logic [11:0] rand_i = '0;
  logic [11:0] guess_i = '0;
  logic [3:0]  turns_o, spot_o, color_o;
  logic        win_o, lose_o;
  logic [7:0]  end_digits_o;

  int vectors = 0;
  int errs    = 0;
  bit done    = 1'b0;

  int          m_turns, m_spot, m_color;
  bit          m_win, m_lose;
  logic [11:0] m_code;

  always #5 clk_i = ~clk_i;

  codebreak_ctrl u_codebreak_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_game_i(new_game_i), .submit_i(submit_i),
    .rand_i(rand_i), .guess_i(guess_i), .turns_o(turns_o), .spot_o(spot_o),
    .color_o(color_o), .win_o(win_o), .lose_o(lose_o), .end_digits_o(end_digits_o)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string t_turn, string t_end);
    chk(t_turn, int'(turns_o), m_turns);
    chk("R5 spot", int'(spot_o), m_spot);
    chk("R6 color", int'(color_o), m_color);
    chk({t_end, " win"}, int'(win_o), int'(m_win));
    chk({t_end, " lose"}, int'(lose_o), int'(m_lose));
    chk({t_end, " digits"}, int'(end_digits_o), m_win ? 'h66 : (m_lose ? 'h60 : 0));
  endtask

  task automatic start_game(logic [11:0] code);
    @(negedge clk_i);
    rand_i = code;
    new_game_i = 1'b1;
    repeat (4) @(negedge clk_i);
    new_game_i = 1'b0;
    repeat (4) @(negedge clk_i);
    m_code = code; m_turns = 9; m_spot = 0; m_color = 0; m_win = 0; m_lose = 0;
    chk_all("R2 turns", "R2");
  endtask

  task automatic do_guess(logic [11:0] g);
    string tt, te;
    int s, c;
    tt = "R4 turns"; te = "R7";
    if (!m_win && !m_lose) begin
      s = 0; c = 0;
      for (int i = 0; i < 4; i++) begin
        bit found;
        found = 0;
        if (g[3*i +: 3] == m_code[3*i +: 3]) s++;
        else begin
          for (int j = 0; j < 4; j++)
            if (j != i && g[3*i +: 3] == m_code[3*j +: 3]) found = 1;
          if (found) c++;
        end
      end
      m_turns--; m_spot = s; m_color = c;
      if (s == 4) begin m_win = 1; if (m_turns == 0) te = "R9"; end
      else if (m_turns == 0) begin m_lose = 1; te = "R8"; end
    end else begin
      te = m_win ? "R7" : "R8";
      tt = m_win ? "R7 turns" : "R8 turns";
    end
    @(negedge clk_i);
    guess_i = g;
    submit_i = 1'b1;
    repeat (4) @(negedge clk_i);
    submit_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk_all(tt, te);
    rand_i = ~rand_i ^ 12'h5a3;  // R3: code must not follow this
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    m_turns = 9; m_spot = 0; m_color = 0; m_win = 0; m_lose = 0;
    chk_all("R1 turns", "R1");
    rst_ni = 1'b1;

    // game 1: loss on ninth guess, repeated-colour scoring
    start_game(12'o1234);
    do_guess(12'o4321);
    do_guess(12'o1243);
    do_guess(12'o1111);
    do_guess(12'o5670);
    do_guess(12'o2134);
    do_guess(12'o0000);
    do_guess(12'o7777);
    do_guess(12'o3412);
    do_guess(12'o1235);
    do_guess(12'o1234);  // ignored after loss

    // game 2: restart mid-game, then quick win
    start_game(12'o7770);
    do_guess(12'o0777);
    do_guess(12'o1234);
    start_game(12'o3303);
    do_guess(12'o3303);
    do_guess(12'o0000);  // ignored after win

    // game 3: win on the last turn
    start_game(12'o5050);
    do_guess(12'o0505);
    do_guess(12'o5500);
    do_guess(12'o0055);
    do_guess(12'o5005);
    do_guess(12'o5555);
    do_guess(12'o0000);
    do_guess(12'o5051);
    do_guess(12'o1050);
    do_guess(12'o5050);
    do_guess(12'o1111);

    // sweep
    start_game(12'd91);
    for (int k = 0; k < 120; k++) begin
      logic [11:0] g;
      if (m_win || m_lose) start_game(12'((k * 1237 + 91) & 'hfff));
      g = 12'(((k * 613) ^ (k << 5)) & 'hfff);
      if (k % 7 == 3) g = m_code;
      if (k % 11 == 5) g = {m_code[2:0], m_code[11:3]};
      do_guess(g);
    end

    // asynchronous reset mid-game
    start_game(12'o6420);
    do_guess(12'o0246);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    m_turns = 9; m_spot = 0; m_color = 0; m_win = 0; m_lose = 0;
    chk_all("R1 turns", "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule